// File: doc/BRIEF.md
# Extended I/O Interrupt Router

The block gathers a wide bank of device interrupt lines (256 by default, 128 in a reduced build) for a single node. Each line that is high at a clock edge marks its vector pending. A pending vector reaches a core only when three things hold: its own enable bit is set, the controller-wide enable is on, and its routing information names a valid target. The outputs form a matrix of request lines, one for each pair of target core and core interrupt pin.

Software programs the router through a 64-bit register port with byte strobes, so 32-bit and single-byte accesses are also possible. Every vector has a route byte. In the normal mode this byte holds a core bitmap and a node number. In the CPU-encoded mode the whole byte is a binary core number. Each group of 32 vectors shares a pin-select byte. A per-vector bounce bit spreads successive deliveries of a multi-core vector across the cores it names. Software services a vector by writing a one to its pending bit.

Top module: `xirq_router`

## Requirements
- R1: A vector whose input is high at a rising edge becomes pending and stays pending until software clears it. Pending bits read back as 64-bit words at 0x1800 + 8*(v>>6), bit v%64, whatever the vector's enable.
- R2: Writing a one to a pending bit clears it and writing a zero leaves it alone. If the vector's input is high at the same edge, the bit stays set.
- R3: Vector v's enable bit sits at 0x1600 + 4*(v>>5), bit v&31, which is the same as 64-bit word 0x1600 + 8*(v>>6), bit v%64. While the bit is clear the vector drives no output and stays pending. Setting the bit again delivers the vector.
- R4: Bit 0 of the control word at 0x1400 is the global enable. While it is 0, every output is low.
- R5: Vector v's route byte is in the word at 0x1C00 + (v & ~3), byte lane (v & 3). In normal mode, bits [3:0] name target cores as a bitmap and bits [7:4] give a node number. A vector with a nonzero node number is never delivered.
- R6: In normal mode with the bounce bit clear, the vector goes to the lowest-numbered core named in its bitmap.
- R7: Bounce bits use the enable layout at base 0x1680. With bounce set, the vector goes to the first named core at or above a per-vector rotation pointer, wrapping around. The pointer resets to 0. Clearing the pending bit of a delivered vector moves the pointer to one past the core that was served.
- R8: Byte k at 0x14C0 + k selects the pin for vectors 32k..32k+31. The lowest set bit among bits [3:0] gives the pin. A byte with none of those bits set delivers nothing.
- R9: Control bit 1 selects CPU-encoded mode. In this mode the whole route byte is a binary core number, and values of 4 or more are not delivered.
- R10: Output bit core*4+pin is the OR over all vectors delivered to that core and pin. The outputs are registered, so they follow a change of pending or register state one clock later.
- R11: Registers are 64-bit words selected by address bits [12:3]. Only bytes whose strobe is set are written. Read data is registered and valid in the cycle after the read request.
- R12: After reset all registers, rotation pointers, pending bits and outputs are zero.
- R13: Addresses outside the mapped regions read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_VEC (256) | Device interrupt lines, one per vector |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address; bits [2:0] are ignored |
| req_wdata | input | 64 | Write data |
| req_wstrb | input | 8 | Byte write strobes |
| rsp_rdata | output | 64 | Read data, valid the cycle after a read |
| irq_out | output | NUM_CORES*NUM_PINS (16) | Request lines, bit core*NUM_PINS+pin |

## Verification
The routing path is exercised with several patterns. A single multi-core vector with bounce off shows that the lowest named core is chosen. The same pattern with bounce on walks through three named cores and wraps, which separates a rotating pointer from a fixed choice and checks that the pointer moves only on acknowledge. Vectors in groups with empty, single-bit and multi-bit pin-select bytes show that pins are chosen by the lowest set bit and that an empty byte suppresses delivery. Two vectors pending at once must OR together. The CPU-encoded mode is tried with route bytes that are in range and out of range, and the normal mode with a nonzero node field, so that a wrong decode of the byte shows up.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   localparam int ADDR_W = 13;
   localparam int BUS_W  = 64;
   localparam int LANES  = BUS_W / 8;
   localparam int WIDX_W = ADDR_W - 3;

   localparam logic [ADDR_W-1:0] OFS_CTRL   = 13'h1400;
   localparam logic [ADDR_W-1:0] OFS_PINSEL = 13'h14C0;
   localparam logic [ADDR_W-1:0] OFS_ENABLE = 13'h1600;
   localparam logic [ADDR_W-1:0] OFS_BOUNCE = 13'h1680;
   localparam logic [ADDR_W-1:0] OFS_STATUS = 13'h1800;
   localparam logic [ADDR_W-1:0] OFS_ROUTE  = 13'h1C00;

   typedef struct packed {
      logic cpu_mode;
      logic glb_en;
   } ctrl_t;

   // byte number byte_idx of a region at base is addressed and strobed
   function automatic logic lane_hit(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input int                byte_idx,
                                     input logic [LANES-1:0]  strb);
      logic [WIDX_W-1:0] word;
      word = base[ADDR_W-1:3] + WIDX_W'(byte_idx / LANES);
      return (addr[ADDR_W-1:3] == word) && strb[3'(byte_idx % LANES)];
   endfunction

   // 64-bit word number w of a region at base is addressed
   function automatic logic word_hit(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input int                w);
      return addr[ADDR_W-1:3] == (base[ADDR_W-1:3] + WIDX_W'(w));
   endfunction

endpackage

// File: rtl/xirq_regfile.sv
module xirq_regfile
   import xirq_pkg::*;
#(
   parameter int NUM_VEC = 256
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [BUS_W-1:0]            req_wdata,
   input  logic [LANES-1:0]            req_wstrb,
   input  logic [NUM_VEC-1:0]          pend_q,
   output logic [BUS_W-1:0]            rsp_rdata,
   output ctrl_t                       ctrl_q,
   output logic [NUM_VEC-1:0]          en_q,
   output logic [NUM_VEC-1:0]          bnc_q,
   output logic [NUM_VEC/4-1:0]        pinsel_q,
   output logic [NUM_VEC-1:0][7:0]     route_q,
   output logic [NUM_VEC-1:0]          pend_clr
);

   localparam int VEC_B  = NUM_VEC / 8;     // bytes of a one-bit-per-vector region
   localparam int VEC_WD = NUM_VEC / 64;    // words of such a region
   localparam int PS_B   = NUM_VEC / 32;    // pin-select bytes
   localparam int RT_WD  = NUM_VEC / 8;     // route words

   logic             wr, rd;
   logic [BUS_W-1:0] rd_word;
   wire              unused_addr = ^req_addr[2:0];

   assign wr = req_valid & req_write;
   assign rd = req_valid & ~req_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         en_q     <= '0;
         bnc_q    <= '0;
         pinsel_q <= '0;
         route_q  <= '0;
      end else if (wr) begin
         if (lane_hit(req_addr, OFS_CTRL, 0, req_wstrb)) begin
            ctrl_q.glb_en   <= req_wdata[0];
            ctrl_q.cpu_mode <= req_wdata[1];
         end
         for (int j = 0; j < VEC_B; j++) begin
            if (lane_hit(req_addr, OFS_ENABLE, j, req_wstrb))
               en_q[j*8 +: 8] <= req_wdata[(j % LANES)*8 +: 8];
            if (lane_hit(req_addr, OFS_BOUNCE, j, req_wstrb))
               bnc_q[j*8 +: 8] <= req_wdata[(j % LANES)*8 +: 8];
         end
         for (int j = 0; j < PS_B; j++) begin
            if (lane_hit(req_addr, OFS_PINSEL, j, req_wstrb))
               pinsel_q[j*8 +: 8] <= req_wdata[(j % LANES)*8 +: 8];
         end
         for (int j = 0; j < NUM_VEC; j++) begin
            if (lane_hit(req_addr, OFS_ROUTE, j, req_wstrb))
               route_q[j] <= req_wdata[(j % LANES)*8 +: 8];
         end
      end
   end

   // write-one-to-clear request towards the pending store
   always_comb begin
      pend_clr = '0;
      if (wr) begin
         for (int j = 0; j < VEC_B; j++) begin
            if (lane_hit(req_addr, OFS_STATUS, j, req_wstrb))
               pend_clr[j*8 +: 8] = req_wdata[(j % LANES)*8 +: 8];
         end
      end
   end

   always_comb begin
      rd_word = '0;
      if (word_hit(req_addr, OFS_CTRL, 0))
         rd_word = BUS_W'({ctrl_q.cpu_mode, ctrl_q.glb_en});
      if (word_hit(req_addr, OFS_PINSEL, 0))
         rd_word = BUS_W'(pinsel_q);
      for (int w = 0; w < VEC_WD; w++) begin
         if (word_hit(req_addr, OFS_ENABLE, w)) rd_word = en_q[w*64 +: 64];
         if (word_hit(req_addr, OFS_BOUNCE, w)) rd_word = bnc_q[w*64 +: 64];
         if (word_hit(req_addr, OFS_STATUS, w)) rd_word = pend_q[w*64 +: 64];
      end
      for (int w = 0; w < RT_WD; w++) begin
         if (word_hit(req_addr, OFS_ROUTE, w)) begin
            for (int b = 0; b < LANES; b++)
               rd_word[b*8 +: 8] = route_q[w*LANES + b];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rsp_rdata <= '0;
      else if (rd) rsp_rdata <= rd_word;
   end

endmodule

// File: rtl/xirq_pending.sv
module xirq_pending #(
   parameter int NUM_VEC = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] irq_in,
   input  logic [NUM_VEC-1:0] pend_clr,
   output logic [NUM_VEC-1:0] pend_q
);

   // a line that is still high wins over a clear at the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~pend_clr) | irq_in;
   end

endmodule

// File: rtl/xirq_vec_route.sv
module xirq_vec_route #(
   parameter int NUM_CORES = 4,
   parameter int NUM_PINS  = 4,
   parameter bit ROTATE_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pend,
   input  logic                          en,
   input  logic                          bounce,
   input  logic                          glb_en,
   input  logic                          cpu_mode,
   input  logic [7:0]                    route,
   input  logic [7:0]                    pinsel,
   input  logic                          ack,
   output logic [NUM_CORES*NUM_PINS-1:0] req
);

   localparam int NOUT = NUM_CORES * NUM_PINS;
   localparam int CW   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

   if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
      $error("xirq_vec_route: NUM_CORES must be 1..4");
   end
   if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
      $error("xirq_vec_route: NUM_PINS must be 1..8");
   end

   logic [CW-1:0] start_c;
   logic          core_hit, pin_hit, deliver;
   int            sel, pin;
   wire           unused_pinsel = ^pinsel;

   always_comb begin
      core_hit = 1'b0;
      sel      = 0;
      if (cpu_mode) begin
         if (int'(route) < NUM_CORES) begin
            core_hit = 1'b1;
            sel      = int'(route);
         end
      end else if (route[7:4] == 4'd0) begin
         // walk downwards so the nearest core above start_c wins
         for (int off = NUM_CORES - 1; off >= 0; off--) begin
            if (route[3'((int'(start_c) + off) % NUM_CORES)]) begin
               core_hit = 1'b1;
               sel      = (int'(start_c) + off) % NUM_CORES;
            end
         end
      end
   end

   always_comb begin
      pin_hit = 1'b0;
      pin     = 0;
      for (int k = NUM_PINS - 1; k >= 0; k--) begin
         if (pinsel[3'(k)]) begin
            pin_hit = 1'b1;
            pin     = k;
         end
      end
   end

   assign deliver = pend & en & glb_en & core_hit & pin_hit;

   always_comb begin
      req = '0;
      if (deliver) req = {{(NOUT-1){1'b0}}, 1'b1} << (sel * NUM_PINS + pin);
   end

   if (ROTATE_EN) begin : g_rotate
      logic [CW-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ptr_q <= '0;
         else if (ack && deliver && bounce && !cpu_mode)
            ptr_q <= CW'((sel + 1) % NUM_CORES);
      end
      assign start_c = bounce ? ptr_q : '0;
   end else begin : g_fixed
      wire unused_rot = bounce ^ ack;
      assign start_c = '0;
   end

endmodule

// File: rtl/xirq_router.sv
module xirq_router
   import xirq_pkg::*;
#(
   parameter int NUM_VEC   = 256,
   parameter int NUM_CORES = 4,
   parameter int NUM_PINS  = 4,
   parameter bit ROTATE_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_VEC-1:0]            irq_in,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [12:0]                   req_addr,
   input  logic [63:0]                   req_wdata,
   input  logic [7:0]                    req_wstrb,
   output logic [63:0]                   rsp_rdata,
   output logic [NUM_CORES*NUM_PINS-1:0] irq_out
);

   localparam int NOUT   = NUM_CORES * NUM_PINS;
   localparam int GROUPS = NUM_VEC / 32;

   if (NUM_VEC % 64 != 0 || NUM_VEC < 64 || NUM_VEC > 256) begin : g_bad_vec
      $error("xirq_router: NUM_VEC must be a multiple of 64 in 64..256");
   end
   if (GROUPS * 8 > BUS_W) begin : g_bad_groups
      $error("xirq_router: pin-select bytes exceed one word");
   end

   ctrl_t                   ctrl_q;
   logic                    glb_en_w;
   logic [NUM_VEC-1:0]      en_q, bnc_q, pend_q, pend_clr;
   logic [NUM_VEC/4-1:0]    pinsel_q;
   logic [NUM_VEC-1:0][7:0] route_q;
   logic [NUM_VEC-1:0][NOUT-1:0] vec_req;
   logic [NOUT-1:0]         out_d;

   assign glb_en_w = ctrl_q.glb_en;

   xirq_regfile #(.NUM_VEC(NUM_VEC)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_wstrb (req_wstrb),
      .pend_q    (pend_q),
      .rsp_rdata (rsp_rdata),
      .ctrl_q    (ctrl_q),
      .en_q      (en_q),
      .bnc_q     (bnc_q),
      .pinsel_q  (pinsel_q),
      .route_q   (route_q),
      .pend_clr  (pend_clr)
   );

   xirq_pending #(.NUM_VEC(NUM_VEC)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .pend_clr (pend_clr),
      .pend_q   (pend_q)
   );

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      xirq_vec_route #(
         .NUM_CORES (NUM_CORES),
         .NUM_PINS  (NUM_PINS),
         .ROTATE_EN (ROTATE_EN)
      ) u_route (
         .clk      (clk),
         .rst_n    (rst_n),
         .pend     (pend_q[v]),
         .en       (en_q[v]),
         .bounce   (bnc_q[v]),
         .glb_en   (ctrl_q.glb_en),
         .cpu_mode (ctrl_q.cpu_mode),
         .route    (route_q[v]),
         .pinsel   (pinsel_q[(v/32)*8 +: 8]),
         .ack      (pend_clr[v]),
         .req      (vec_req[v])
      );
   end

   always_comb begin
      out_d = '0;
      for (int v = 0; v < NUM_VEC; v++) out_d |= vec_req[v];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= '0;
      else        irq_out <= out_d;
   end

endmodule

// File: rtl/xirq_router_chk.sv
module xirq_router_chk #(
   parameter int NUM_VEC = 256,
   parameter int NOUT    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_VEC-1:0] irq_in,
   input logic [NUM_VEC-1:0] pend_q,
   input logic [NUM_VEC-1:0] pend_clr,
   input logic [NUM_VEC-1:0] en_q,
   input logic               glb_en,
   input logic [NOUT-1:0]    irq_out
);

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_in) |=> ((pend_q & $past(irq_in)) == $past(irq_in)));   // R1

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend_q) |=> (($past(pend_q) & ~$past(pend_clr) & ~pend_q) == '0));   // R1

   AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_clr & ~irq_in)) |=> ((pend_q & $past(pend_clr & ~irq_in)) == '0));   // R2

   AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> (irq_out == '0));   // R4

   AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_out) |-> $past(|(pend_q & en_q)));   // R3

endmodule

bind xirq_router xirq_router_chk #(.NUM_VEC(NUM_VEC), .NOUT(NOUT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_in   (irq_in),
   .pend_q   (pend_q),
   .pend_clr (pend_clr),
   .en_q     (en_q),
   .glb_en   (glb_en_w),
   .irq_out  (irq_out)
);

// File: tb/xirq_router_bench.sv
module xirq_router_bench;

   localparam int NV = 256;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NV-1:0] irq_in;
   logic          req_valid, req_write;
   logic [12:0]   req_addr;
   logic [63:0]   req_wdata;
   logic [7:0]    req_wstrb;
   logic [63:0]   rsp_rdata;
   logic [15:0]   irq_out;

   int checks   = 0;
   int failures = 0;

   always #4 clk = ~clk;

   xirq_router u_xirq_router (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_wstrb (req_wstrb),
      .rsp_rdata (rsp_rdata),
      .irq_out   (irq_out)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [12:0] a, input logic [63:0] d, input logic [7:0] s);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_wstrb = s;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wstrb = '0;
   endtask

   task automatic bus_rd(input logic [12:0] a, output logic [63:0] d);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      d = rsp_rdata;
      req_valid = 1'b0;
   endtask

   task automatic pulse(input int v);
      irq_in[v] = 1'b1;
      @(negedge clk);
      irq_in[v] = 1'b0;
   endtask

   // registered outputs follow state one clock later
   task automatic out_is(input string tag, input logic [15:0] e);
      @(negedge clk);
      chk(tag, 64'(irq_out), 64'(e));
   endtask

   task automatic t_reset;
      logic [63:0] d;
      chk("R12 outputs after reset", 64'(irq_out), 64'h0);
      bus_rd(13'h1400, d); chk("R12 control after reset", d, 64'h0);
      bus_rd(13'h1600, d); chk("R12 enable after reset", d, 64'h0);
      bus_rd(13'h1C00, d); chk("R12 route after reset", d, 64'h0);
      bus_rd(13'h1800, d); chk("R12 status after reset", d, 64'h0);
      bus_rd(13'h14C0, d); chk("R12 pin select after reset", d, 64'h0);
      // groups: 0->pin0, 1->pin2, 2->none, 3->lowest of {1,3}, rest pin3
      bus_wr(13'h14C0, 64'h0808_0808_0A00_0401, 8'hFF);
      bus_wr(13'h1400, 64'h1, 8'h01);
      bus_rd(13'h1400, d); chk("R4 control readback", d, 64'h1);
   endtask

   task automatic t_pending;
      logic [63:0] d;
      pulse(5);
      bus_rd(13'h1800, d); chk("R1 disabled vector still pending", d, 64'h20);
      out_is("R3 disabled vector not delivered", 16'h0);
      pulse(6);
      bus_wr(13'h1800, 64'h40, 8'hFF);
      bus_rd(13'h1800, d); chk("R2 one clears, zero keeps", d, 64'h20);
      bus_wr(13'h1800, 64'h20, 8'hFF);
      bus_rd(13'h1800, d); chk("R2 clear last bit", d, 64'h0);
      irq_in[6] = 1'b1;
      @(negedge clk);
      bus_wr(13'h1800, 64'h40, 8'hFF);
      bus_rd(13'h1800, d); chk("R2 held input beats clear", d, 64'h40);
      irq_in[6] = 1'b0;
      bus_wr(13'h1800, 64'h40, 8'hFF);
      bus_rd(13'h1800, d); chk("R2 clear after release", d, 64'h0);
   endtask

   task automatic t_deliver;
      logic [63:0] d;
      bus_wr(13'h1C00, 64'h06 << 40, 8'h20);
      bus_rd(13'h1C00, d); chk("R11 single-lane route write", d, 64'h0000_0600_0000_0000);
      bus_wr(13'h1600, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01);
      bus_rd(13'h1600, d); chk("R11 strobe limits enable write", d, 64'hFF);
      bus_wr(13'h1600, 64'h20, 8'hFF);
      bus_rd(13'h1600, d); chk("R3 enable bit 5", d, 64'h20);
      pulse(5);
      out_is("R6 lowest named core, pin0", 16'h0010);
      bus_wr(13'h1600, 64'h0, 8'hFF);
      out_is("R3 cleared enable masks output", 16'h0);
      bus_rd(13'h1800, d); chk("R3 masked vector stays pending", d, 64'h20);
      bus_wr(13'h1C00, 64'h12 << 40, 8'h20);
      bus_wr(13'h1600, 64'h20, 8'hFF);
      out_is("R5 nonzero node not delivered", 16'h0);
      bus_wr(13'h1C00, 64'h06 << 40, 8'h20);
      out_is("R3 re-enable delivers", 16'h0010);
      bus_wr(13'h1800, 64'h20, 8'hFF);
      out_is("R10 output drops after clear", 16'h0);
   endtask

   task automatic t_bounce;
      bus_wr(13'h1C28, 64'h0B, 8'h01);               // vector 40: cores 0,1,3
      bus_wr(13'h1600, (64'h1 << 40) | 64'h20, 8'hFF);
      bus_wr(13'h1680, 64'h1 << 40, 8'hFF);
      pulse(40);
      out_is("R7 rotation first core0", 16'h0004);
      out_is("R7 no advance without ack", 16'h0004);
      bus_wr(13'h1800, 64'h1 << 40, 8'hFF);
      out_is("R7 cleared", 16'h0);
      pulse(40);
      out_is("R7 rotation to core1", 16'h0040);
      bus_wr(13'h1800, 64'h1 << 40, 8'hFF);
      pulse(40);
      out_is("R7 rotation skips core2 to core3", 16'h4000);
      bus_wr(13'h1800, 64'h1 << 40, 8'hFF);
      pulse(40);
      out_is("R7 rotation wraps to core0", 16'h0004);
      bus_wr(13'h1800, 64'h1 << 40, 8'hFF);
      out_is("R7 final clear", 16'h0);
   endtask

   task automatic t_pins;
      bus_wr(13'h1C40, 64'h01 << 48, 8'h40);          // vector 70, group 2
      bus_wr(13'h1C60, 64'h01 << 32, 8'h10);          // vector 100, group 3
      bus_wr(13'h1608, (64'h1 << 36) | (64'h1 << 6), 8'hFF);
      irq_in[70] = 1'b1; irq_in[100] = 1'b1;
      @(negedge clk);
      irq_in[70] = 1'b0; irq_in[100] = 1'b0;
      out_is("R8 empty pin byte suppressed, lowest pin bit", 16'h0002);
      pulse(5);
      out_is("R10 OR of two vectors", 16'h0012);
      bus_wr(13'h1800, 64'h20, 8'hFF);
      out_is("R10 one vector left", 16'h0002);
   endtask

   task automatic t_global;
      logic [63:0] d;
      bus_wr(13'h1400, 64'h0, 8'h01);
      out_is("R4 global disable", 16'h0);
      bus_rd(13'h1808, d); chk("R4 pending kept while disabled", d, (64'h1 << 36) | (64'h1 << 6));
      bus_wr(13'h1400, 64'h1, 8'h01);
      out_is("R4 global re-enable", 16'h0002);
   endtask

   task automatic t_cpu_mode;
      bus_wr(13'h1400, 64'h3, 8'h01);
      out_is("R9 binary core 1", 16'h0020);
      bus_wr(13'h1C60, 64'h03 << 32, 8'h10);
      out_is("R9 binary core 3", 16'h2000);
      bus_wr(13'h1C60, 64'h10 << 32, 8'h10);
      out_is("R9 out-of-range core", 16'h0);
      bus_wr(13'h1400, 64'h1, 8'h01);
      out_is("R5 normal mode node field", 16'h0);
      bus_wr(13'h1C60, 64'h01 << 32, 8'h10);
      out_is("R5 normal mode core0", 16'h0002);
   endtask

   task automatic t_unmapped;
      logic [63:0] d;
      bus_rd(13'h1000, d); chk("R13 unmapped read", d, 64'h0);
      bus_wr(13'h1010, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
      bus_rd(13'h1010, d); chk("R13 unmapped write ignored", d, 64'h0);
      out_is("R13 outputs unchanged", 16'h0002);
   endtask

   initial begin
      rst_n = 1'b0; irq_in = '0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; req_wstrb = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pending();
      t_deliver();
      t_bounce();
      t_pins();
      t_global();
      t_cpu_mode();
      t_unmapped();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 100000);
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule